// File: doc/BRIEF.md
# Late-Write Buffer with Read Bypass

This block sits between a synchronous command front end and a single-port memory array made of two-word lines. When a write command arrives, the block registers its address. The one or two data words for that write come in on the cycle after the command, and the block holds them in a pending entry. The pending entry is not written to the array in its own cycle. It is written when the next write command arrives, however many reads or idle cycles come in between. The new write's address is captured in that same cycle.

Every read is checked word by word against the pending entry. Each word of a read whose word address matches a word held in the entry is served from the entry. The other words come from the array. This is done with the same latency as a plain array read, so the late write cannot be seen at the read port. The array line is twice the external word width, so one array write stores both prefetched words.

Top module: `late_write_buf`

## Requirements
- R1: A command is sampled at a rising edge when `cmd_load_n` is low. `cmd_rw_n` low means a write and high means a read. A cycle with `cmd_load_n` high is idle: it writes nothing to the array, and it yields no read result (`rd_valid` 0, both read words 0).
- R2: The write data words are taken only in the cycle right after the write command. Values on `wr_word0`/`wr_word1` in any other cycle have no effect.
- R3: `mem_we` is high only in a cycle that presents a write command while an earlier write is still pending. The first write after reset does not write the array.
- R4: The pending entry survives any number of read and idle cycles. When it is committed, `mem_addr` carries its line, which is the word address without bit 0.
- R5: A read sampled at edge E gives `rd_valid` high after edge E+1, with its words on `rd_word0`/`rd_word1`.
- R6: `rd_word0` is the current value of the word at `cmd_addr`. It is taken from the pending entry when that word is pending, and from the array otherwise.
- R7: For a double read (`cmd_dbl` high), `rd_word1` is the word at `cmd_addr` with bit 0 inverted. It is forwarded on its own when only that word is pending. For a single read it is 0.
- R8: Reset clears the pending entry. No read is forwarded, and no commit takes place, until a new write has been taken.
- R9: When two write commands come in consecutive cycles, the first write's data, which arrives in the second write's cycle, is the data committed in that cycle.
- R10: Word slot i of a line holds the word whose address bit 0 equals i. `mem_wdata` slot i is bits [i*DW +: DW], and `mem_wmask` bit i enables slot i. A single write at address bit 0 = b enables only slot b. A double write enables both slots, with `wr_word0` in slot b and `wr_word1` in the other slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_load_n | input | 1 | Low: a command is presented this cycle |
| cmd_rw_n | input | 1 | Low: write, high: read |
| cmd_dbl | input | 1 | High: two-word access |
| cmd_addr | input | AW | Word address of the first word |
| wr_word0 | input | DW | First write word (cycle after command) |
| wr_word1 | input | DW | Second write word (double writes) |
| mem_addr | output | AW-1 | Array line address |
| mem_we | output | 1 | Array write strobe (commit) |
| mem_wmask | output | 2 | Per-slot write enable |
| mem_wdata | output | 2*DW | Line write data, slot i at [i*DW +: DW] |
| mem_rdata | input | 2*DW | Array line read one cycle after `mem_addr` |
| rd_valid | output | 1 | Read result valid |
| rd_word0 | output | DW | Word at the read address |
| rd_word1 | output | DW | Paired word (double read) or 0 |

## Verification
The checker watches, on every cycle, the control relations. A write command always leaves a valid entry and a data slot due next cycle. Between writes the pending line and mask hold still. Nothing is forwarded while no entry is valid. A commit always carries a non-empty mask. Read results appear exactly two edges after a read command and at no other time. Whether the data is right can only be shown by the bench's scenarios: forwarding on a full or partial match, commit contents after reads and after back-to-back writes, data ignored outside its cycle, and loss of the pending entry at reset. The bench compares these against a word-level model of the memory and its own model of the pending entry.

// File: rtl/lwb_pkg.sv
package lwb_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } cmd_e;

  function automatic cmd_e decode_cmd(input logic load_n, input logic rw_n);
    if (load_n) return CMD_IDLE;
    return rw_n ? CMD_READ : CMD_WRITE;
  endfunction

  // slot enables touched by an access starting at word slot lsb
  function automatic logic [1:0] word_mask(input logic lsb, input logic dbl);
    if (dbl) return 2'b11;
    return lsb ? 2'b10 : 2'b01;
  endfunction

  // word slot addressed by burst beat b of an access starting at lsb
  function automatic logic beat_lsb(input logic lsb, input logic b);
    return lsb ^ b;
  endfunction

endpackage

// File: rtl/lwb_pend_store.sv
module lwb_pend_store
  import lwb_pkg::*;
#(
  parameter int LW = 5,
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_cmd,
  input  logic [LW-1:0]        cmd_line,
  input  logic                 cmd_lsb,
  input  logic                 cmd_dbl,
  input  logic [DW-1:0]        wd0,
  input  logic [DW-1:0]        wd1,
  output logic                 pend_valid,
  output logic [LW-1:0]        pend_line,
  output logic [1:0]           pend_mask,
  output logic [1:0][DW-1:0]   pend_data,
  output logic                 data_due,
  output logic                 commit_fire,
  output logic [1:0][DW-1:0]   commit_data
);

  logic pend_lsb;
  logic pend_dbl;
  logic [1:0][DW-1:0] arriving;

  // steer the incoming words into line slots
  function automatic logic [1:0][DW-1:0] place_words(
    input logic [DW-1:0] a, input logic [DW-1:0] b,
    input logic lsb, input logic dbl);
    logic [1:0][DW-1:0] s;
    s = '0;
    s[lsb] = a;
    if (dbl) s[~lsb] = b;
    return s;
  endfunction

  assign arriving    = place_words(wd0, wd1, pend_lsb, pend_dbl);
  assign commit_fire = wr_cmd && pend_valid;
  // back-to-back writes: old data is still on the input pins
  assign commit_data = data_due ? arriving : pend_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_line  <= '0;
      pend_mask  <= '0;
      pend_lsb   <= 1'b0;
      pend_dbl   <= 1'b0;
      pend_data  <= '0;
      data_due   <= 1'b0;
    end else begin
      data_due <= wr_cmd;
      if (data_due) pend_data <= arriving;
      if (wr_cmd) begin
        pend_valid <= 1'b1;
        pend_line  <= cmd_line;
        pend_lsb   <= cmd_lsb;
        pend_dbl   <= cmd_dbl;
        pend_mask  <= word_mask(cmd_lsb, cmd_dbl);
      end
    end
  end

endmodule

// File: rtl/lwb_bypass_cmp.sv
module lwb_bypass_cmp
  import lwb_pkg::*;
#(
  parameter int LW = 5,
  parameter int DW = 16
) (
  input  logic                 pend_valid,
  input  logic [LW-1:0]        pend_line,
  input  logic [1:0]           pend_mask,
  input  logic [1:0][DW-1:0]   pend_data,
  input  logic [LW-1:0]        q_line,
  input  logic                 q_lsb,
  input  logic                 q_dbl,
  output logic [1:0]           hit,
  output logic [1:0][DW-1:0]   fwd
);

  for (genvar b = 0; b < 2; b++) begin : g_beat
    logic slot;
    logic beat_used;
    assign slot      = beat_lsb(q_lsb, 1'(b));
    assign beat_used = (b == 0) || q_dbl;
    assign hit[b]    = pend_valid && beat_used &&
                       (q_line == pend_line) && pend_mask[slot];
    assign fwd[b]    = pend_data[slot];
  end

endmodule

// File: rtl/lwb_rd_stage.sv
module lwb_rd_stage
  import lwb_pkg::*;
#(
  parameter int LW = 5,
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_cmd,
  input  logic [LW-1:0]        cmd_line,
  input  logic                 cmd_lsb,
  input  logic                 cmd_dbl,
  input  logic [1:0][DW-1:0]   mem_line,
  input  logic [1:0]           hit,
  input  logic [1:0][DW-1:0]   fwd,
  output logic [LW-1:0]        q_line,
  output logic                 q_lsb,
  output logic                 q_dbl,
  output logic                 rd_valid,
  output logic [1:0][DW-1:0]   rd_words
);

  logic q_valid;
  logic [1:0][DW-1:0] nxt;

  for (genvar b = 0; b < 2; b++) begin : g_sel
    logic slot;
    assign slot = beat_lsb(q_lsb, 1'(b));
    always_comb begin
      nxt[b] = hit[b] ? fwd[b] : mem_line[slot];
      if (!q_valid || ((b == 1) && !q_dbl)) nxt[b] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid  <= 1'b0;
      q_line   <= '0;
      q_lsb    <= 1'b0;
      q_dbl    <= 1'b0;
      rd_valid <= 1'b0;
      rd_words <= '0;
    end else begin
      q_valid  <= rd_cmd;
      if (rd_cmd) begin
        q_line <= cmd_line;
        q_lsb  <= cmd_lsb;
        q_dbl  <= cmd_dbl;
      end
      rd_valid <= q_valid;
      rd_words <= nxt;
    end
  end

endmodule

// File: rtl/late_write_buf.sv
module late_write_buf
  import lwb_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_load_n,
  input  logic              cmd_rw_n,
  input  logic              cmd_dbl,
  input  logic [AW-1:0]     cmd_addr,
  input  logic [DW-1:0]     wr_word0,
  input  logic [DW-1:0]     wr_word1,
  output logic [AW-2:0]     mem_addr,
  output logic              mem_we,
  output logic [1:0]        mem_wmask,
  output logic [2*DW-1:0]   mem_wdata,
  input  logic [2*DW-1:0]   mem_rdata,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_word0,
  output logic [DW-1:0]     rd_word1
);

  localparam int LW = AW - 1;

  cmd_e               cmd;
  logic               wr_cmd;
  logic               rd_cmd;
  logic [LW-1:0]      cmd_line;
  logic               cmd_lsb;
  logic               pend_valid;
  logic [LW-1:0]      pend_line;
  logic [1:0]         pend_mask;
  logic [1:0][DW-1:0] pend_data;
  logic               data_due;
  logic               commit_fire;
  logic [1:0][DW-1:0] commit_data;
  logic [LW-1:0]      q_line;
  logic               q_lsb;
  logic               q_dbl;
  logic [1:0]         bp_hit;
  logic [1:0][DW-1:0] bp_fwd;
  logic [1:0][DW-1:0] rd_words;

  assign cmd      = decode_cmd(cmd_load_n, cmd_rw_n);
  assign wr_cmd   = (cmd == CMD_WRITE);
  assign rd_cmd   = (cmd == CMD_READ);
  assign cmd_line = cmd_addr[AW-1:1];
  assign cmd_lsb  = cmd_addr[0];

  lwb_pend_store #(.LW(LW), .DW(DW)) u_pend (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd),
    .cmd_line(cmd_line), .cmd_lsb(cmd_lsb), .cmd_dbl(cmd_dbl),
    .wd0(wr_word0), .wd1(wr_word1),
    .pend_valid(pend_valid), .pend_line(pend_line), .pend_mask(pend_mask),
    .pend_data(pend_data), .data_due(data_due),
    .commit_fire(commit_fire), .commit_data(commit_data)
  );

  lwb_bypass_cmp #(.LW(LW), .DW(DW)) u_cmp (
    .pend_valid(pend_valid), .pend_line(pend_line), .pend_mask(pend_mask),
    .pend_data(pend_data), .q_line(q_line), .q_lsb(q_lsb), .q_dbl(q_dbl),
    .hit(bp_hit), .fwd(bp_fwd)
  );

  lwb_rd_stage #(.LW(LW), .DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd),
    .cmd_line(cmd_line), .cmd_lsb(cmd_lsb), .cmd_dbl(cmd_dbl),
    .mem_line(mem_rdata), .hit(bp_hit), .fwd(bp_fwd),
    .q_line(q_line), .q_lsb(q_lsb), .q_dbl(q_dbl),
    .rd_valid(rd_valid), .rd_words(rd_words)
  );

  // single array port: the commit owns it on write-command cycles
  assign mem_we    = commit_fire;
  assign mem_addr  = commit_fire ? pend_line : cmd_line;
  assign mem_wmask = commit_fire ? pend_mask : 2'b00;
  assign mem_wdata = commit_data;
  assign rd_word0  = rd_words[0];
  assign rd_word1  = rd_words[1];

endmodule

// File: rtl/lwb_chk.sv
module lwb_chk
  import lwb_pkg::*;
#(
  parameter int LW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_load_n,
  input logic          cmd_rw_n,
  input logic          pend_valid,
  input logic [LW-1:0] pend_line,
  input logic [1:0]    pend_mask,
  input logic          data_due,
  input logic [1:0]    bp_hit,
  input logic          rd_valid,
  input logic          mem_we,
  input logic [1:0]    mem_wmask
);

  logic is_wr;
  logic is_rd;
  assign is_wr = (decode_cmd(cmd_load_n, cmd_rw_n) == CMD_WRITE);
  assign is_rd = (decode_cmd(cmd_load_n, cmd_rw_n) == CMD_READ);

  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    is_wr |=> pend_valid);

  p_data_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_wr |=> data_due);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_valid && !is_wr) |=> (pend_valid && $stable(pend_line) && $stable(pend_mask)));

  p_no_fwd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_valid |-> (bp_hit == 2'b00));

  p_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wmask != 2'b00));

  p_rd_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd |=> ##1 rd_valid);

  p_rd_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !is_rd |=> ##1 !rd_valid);

endmodule

bind late_write_buf lwb_chk #(.LW(AW-1)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_load_n(cmd_load_n), .cmd_rw_n(cmd_rw_n),
  .pend_valid(pend_valid), .pend_line(pend_line), .pend_mask(pend_mask),
  .data_due(data_due), .bp_hit(bp_hit), .rd_valid(rd_valid),
  .mem_we(mem_we), .mem_wmask(mem_wmask)
);

// File: tb/tb_late_write_buf.sv
`timescale 1ns/1ps
module tb_late_write_buf;

  localparam int AW = 6;
  localparam int DW = 16;
  localparam int NR = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_load_n = 1'b1, cmd_rw_n = 1'b1, cmd_dbl = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] wr_word0 = '0, wr_word1 = '0;
  logic [AW-2:0] mem_addr;
  logic mem_we;
  logic [1:0] mem_wmask;
  logic [2*DW-1:0] mem_wdata;
  logic [2*DW-1:0] mem_rdata;
  logic rd_valid;
  logic [DW-1:0] rd_word0, rd_word1;

  always #2 clk = ~clk;

  late_write_buf #(.AW(AW), .DW(DW)) dut (.*);

  // array model: synchronous line read, masked write
  logic [1:0][DW-1:0] arr [32];
  initial for (int l = 0; l < 32; l++) begin
    arr[l][0] = 16'hA000 + 16'(2*l);
    arr[l][1] = 16'hA000 + 16'(2*l+1);
  end
  always @(posedge clk) begin
    if (mem_we) for (int s = 0; s < 2; s++)
      if (mem_wmask[s]) arr[mem_addr][s] <= mem_wdata[s*DW +: DW];
    mem_rdata <= arr[mem_addr];
  end

  int n_total = 0, n_bad = 0;
  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // row: kind[41:40] (0 idle,1 read,2 write) dbl[39] addr[38:33] d0[32:17] d1[16:1] exp_commit[0]
  localparam logic [41:0] ROWS [NR] = '{
    {2'd2, 1'b0, 6'd6,  16'h1111, 16'h0000, 1'b0},
    {2'd1, 1'b0, 6'd6,  16'h0000, 16'h0000, 1'b0},
    {2'd1, 1'b1, 6'd7,  16'h0000, 16'h0000, 1'b0},
    {2'd1, 1'b0, 6'd9,  16'h0000, 16'h0000, 1'b0},
    {2'd2, 1'b1, 6'd9,  16'h2222, 16'h3333, 1'b1},
    {2'd1, 1'b1, 6'd8,  16'h0000, 16'h0000, 1'b0},
    {2'd1, 1'b0, 6'd6,  16'h0000, 16'h0000, 1'b0},
    {2'd2, 1'b0, 6'd9,  16'h4444, 16'h0000, 1'b1},
    {2'd2, 1'b0, 6'd8,  16'h5555, 16'h0000, 1'b1},
    {2'd0, 1'b0, 6'd0,  16'h0000, 16'h0000, 1'b0},
    {2'd1, 1'b1, 6'd9,  16'h0000, 16'h0000, 1'b0},
    {2'd1, 1'b0, 6'd8,  16'h0000, 16'h0000, 1'b0},
    {2'd0, 1'b0, 6'd0,  16'h0000, 16'h0000, 1'b0},
    {2'd2, 1'b0, 6'd0,  16'h6666, 16'h0000, 1'b1},
    {2'd1, 1'b0, 6'd0,  16'h0000, 16'h0000, 1'b0},
    {2'd0, 1'b0, 6'd0,  16'h0000, 16'h0000, 1'b0},
    {2'd0, 1'b0, 6'd0,  16'h0000, 16'h0000, 1'b0}
  };

  logic [DW-1:0] ref_mem [64];
  logic          e_rv [NR];
  logic [DW-1:0] e_w0 [NR];
  logic [DW-1:0] e_w1 [NR];

  // bench view of the pending entry
  logic bp_valid = 1'b0, bp_lsb = 1'b0, bp_dbl = 1'b0;
  logic [4:0] bp_line = '0;
  logic [DW-1:0] bp_d0 = '0, bp_d1 = '0;
  logic prev_wr = 1'b0;

  task automatic drive(input logic [1:0] kind, input logic dbl, input logic [AW-1:0] a);
    cmd_load_n = (kind == 2'd0);
    cmd_rw_n   = (kind != 2'd2);
    cmd_dbl    = dbl;
    cmd_addr   = a;
    if (prev_wr) begin wr_word0 = bp_d0; wr_word1 = bp_d1; end
    else begin wr_word0 = 16'hDEAD; wr_word1 = 16'hBEEF; end
  endtask

  task automatic check_commit(input logic exp_we);
    logic [1:0] em;
    logic [1:0][DW-1:0] ed;
    check("R3 mem_we", 32'(mem_we), 32'(exp_we));
    if (exp_we && mem_we) begin
      em = bp_dbl ? 2'b11 : (bp_lsb ? 2'b10 : 2'b01);
      ed[bp_lsb] = bp_d0;
      ed[~bp_lsb] = bp_d1;
      check("R4 mem_addr", 32'(mem_addr), 32'(bp_line));
      check("R10 mem_wmask", 32'(mem_wmask), 32'(em));
      for (int s = 0; s < 2; s++)
        if (em[s]) check(prev_wr ? "R9 commit data" : "R2 commit data",
                         32'(mem_wdata[s*DW +: DW]), 32'(ed[s]));
    end
  endtask

  task automatic note_write(input logic dbl, input logic [AW-1:0] a,
                            input logic [DW-1:0] d0, input logic [DW-1:0] d1);
    bp_valid = 1'b1; bp_line = a[AW-1:1]; bp_lsb = a[0]; bp_dbl = dbl;
    bp_d0 = d0; bp_d1 = d1;
    ref_mem[a] = d0;
    if (dbl) ref_mem[a ^ 6'd1] = d1;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

  initial begin
    for (int w = 0; w < 64; w++) ref_mem[w] = 16'hA000 + 16'(w);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    drive(2'd0, 1'b0, '0);
    #1;
    check("R8 reset rd_valid", 32'(rd_valid), 32'd0);
    check("R8 reset rd_word0", 32'(rd_word0), 32'd0);
    check("R8 reset mem_we", 32'(mem_we), 32'd0);

    // table walk
    for (int j = 0; j < NR; j++) begin
      logic [1:0] k;
      logic dbl;
      logic [AW-1:0] a;
      k = ROWS[j][41:40]; dbl = ROWS[j][39]; a = ROWS[j][38:33];
      @(negedge clk);
      drive(k, dbl, a);
      #1;
      check_commit(ROWS[j][0]);
      if (j >= 2) begin
        check("R5 rd_valid", 32'(rd_valid), 32'(e_rv[j-2]));
        if (e_rv[j-2]) begin
          check("R6 rd_word0", 32'(rd_word0), 32'(e_w0[j-2]));
          check("R7 rd_word1", 32'(rd_word1), 32'(e_w1[j-2]));
        end else begin
          check("R1 idle rd_word0", 32'(rd_word0), 32'd0);
        end
      end
      e_rv[j] = (k == 2'd1);
      e_w0[j] = ref_mem[a];
      e_w1[j] = dbl ? ref_mem[a ^ 6'd1] : '0;
      if (k == 2'd2) begin
        note_write(dbl, a, ROWS[j][32:17], ROWS[j][16:1]);
        prev_wr = 1'b1;
      end else prev_wr = 1'b0;
    end

    // pending write at 20 then loss at reset (R8)
    @(negedge clk); drive(2'd2, 1'b0, 6'd20); #1; check_commit(1'b1);
    note_write(1'b0, 6'd20, 16'h7777, 16'h0000); prev_wr = 1'b1;
    @(negedge clk); drive(2'd1, 1'b0, 6'd20); prev_wr = 1'b0;
    @(negedge clk); drive(2'd0, 1'b0, '0);
    @(negedge clk); drive(2'd0, 1'b0, '0); #1;
    check("R6 fwd before reset", 32'(rd_word0), 32'h7777);
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; bp_valid = 1'b0; #1;
    check("R8 rd_valid after reset", 32'(rd_valid), 32'd0);
    @(negedge clk); drive(2'd1, 1'b0, 6'd20);
    @(negedge clk); drive(2'd0, 1'b0, '0);
    @(negedge clk); drive(2'd0, 1'b0, '0); #1;
    check("R8 no fwd after reset", 32'(rd_word0), 32'hA014);
    @(negedge clk); drive(2'd2, 1'b0, 6'd2); #1;
    check("R8 first write no commit", 32'(mem_we), 32'd0);
    @(negedge clk); drive(2'd0, 1'b0, '0);
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

endmodule